// File: doc/BRIEF.md
# Power-Down Wake-Up Controller

This block owns the sleep state of a small processor core. When the core issues a halt request, the block marks the core as halted and sets the power-down flag. It then watches five kinds of wake event: an external reset strobe, a watchdog overflow, a period-timer overflow, interrupt request flags and edges on the I/O pins. The first wake event it sees is classified into one of four actions for the core: a full reset, a reset of only the program counter and stack pointer, resuming at the instruction after the halt, or entering the interrupt response.

The action is not released at once. A fixed settling window of `SETTLE_CYC` clock cycles (512 by default) runs first. At the end of the window the action appears on a one-hot output for a single cycle, and the halted indication drops in that same cycle. The block also keeps the time-out flag and the power-down flag that software reads to find out why the core woke. The watchdog counter, the period-timer counter and the interrupt controller lie outside the block. They reach it only as strobes and status levels.

Top module: `pdwake_ctrl`

## Requirements
- R1: A halt request accepted while running raises `halted_o` and `pd_flag_o` in the next cycle. `halt_i` has no effect while the core is halted.
- R2: `act_o` is one-hot with bit 0 = full reset, bit 1 = program counter and stack pointer reset, bit 2 = resume at the next instruction, bit 3 = take interrupt. It is nonzero for exactly one cycle, `SETTLE_CYC` clock edges after the edge that sampled the wake event. `halted_o` falls in that same cycle.
- R3: An external reset strobe while halted yields the full-reset action. `pd_flag_o` and `to_flag_o` read 0 from the cycle the action is issued.
- R4: A watchdog overflow while halted, with `ptr_zero_i` high, yields the program counter and stack pointer reset action. It sets `to_flag_o` in the cycle after the wake edge. The flags are otherwise unchanged: `pd_flag_o` stays 1, and a set `to_flag_o` survives later non-reset wakes.
- R5: With `ptr_zero_i` low, a watchdog overflow is ignored and a period-timer overflow wakes with the resume action. With `ptr_zero_i` high, a period-timer overflow is ignored.
- R6: Each pin of port A has its own enable and polarity bit (1 = rising, 0 = falling). Port X is handled per 4-bit nibble, where any pin of an enabled nibble with the right edge wakes. A pin wake yields the resume action. Disabled pins and edges of the wrong direction are ignored.
- R7: An interrupt wake selects the lowest-numbered live request. It yields the take-interrupt action with `irq_sel_o` holding that index when the line is enabled and `stack_full_i` is low. Otherwise it yields the resume action.
- R8: An interrupt request already set when the halt is accepted is not a wake source for that halt.
- R9: When several sources fire in the same cycle, the order of precedence is external reset, then watchdog or period timer, then interrupt, then pin edge.
- R10: `rst_n` clears `act_o`, `halted_o`, `pd_flag_o` and `to_flag_o`. `wdt_clr_i` while running clears `pd_flag_o` and leaves `to_flag_o` alone.
- R11: An external reset strobe during the settling window changes the pending action to full reset and does not restart the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_i | input | 1 | Halt request strobe from the core |
| wdt_clr_i | input | 1 | Watchdog-clear command strobe |
| ext_rst_i | input | 1 | External reset event strobe |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| ptr_ovf_i | input | 1 | Period-timer overflow strobe |
| ptr_zero_i | input | 1 | Period-timer register holds zero |
| pa_i | input | PA_W | Port A pin levels |
| pa_rise_i | input | PA_W | Port A wake polarity per pin (1 = rising) |
| pa_en_i | input | PA_W | Port A wake enable per pin |
| px_i | input | 4*NIB_N | Port X pin levels |
| px_rise_i | input | NIB_N | Port X wake polarity per nibble |
| px_en_i | input | NIB_N | Port X wake enable per nibble |
| irq_req_i | input | IRQ_N | Interrupt request flags |
| irq_en_i | input | IRQ_N | Interrupt enables |
| stack_full_i | input | 1 | Core stack has no free level |
| halted_o | output | 1 | Core is held (asleep or settling) |
| act_o | output | 4 | One-hot wake action, one-cycle pulse |
| irq_sel_o | output | IW | Index of the interrupt to take |
| pd_flag_o | output | 1 | Power-down status flag |
| to_flag_o | output | 1 | Time-out status flag |

## Verification
The assertions assume that the wake strobes (external reset, watchdog and period-timer overflow) are single-cycle pulses. They also assume that `ptr_zero_i` is steady in the cycle a watchdog strobe is sampled, because the rise of the time-out flag is tied to the watchdog strobe and the zero level seen together one cycle earlier. The bench drives every input on the falling clock edge, so each strobe is seen by exactly one rising edge. Interrupt enable and stack-full levels are set before the halt and held through the wake edge. Pin levels are placed at known values before each halt, so that every recorded edge is one the bench meant to create.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2
  } pdw_state_e;

  localparam int ACT_W = 4;

  // one-hot action codes, bit order is part of the port contract
  localparam logic [ACT_W-1:0] ACT_NONE = 4'b0000;
  localparam logic [ACT_W-1:0] ACT_FULL = 4'b0001;
  localparam logic [ACT_W-1:0] ACT_PCSP = 4'b0010;
  localparam logic [ACT_W-1:0] ACT_NEXT = 4'b0100;
  localparam logic [ACT_W-1:0] ACT_IRQ  = 4'b1000;

endpackage

// File: rtl/pdw_rst_sync.sv
module pdw_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pdw_edge_det.sv
module pdw_edge_det #(
  parameter int PA_W  = 8,
  parameter int NIB_N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PA_W-1:0]    pa_i,
  input  logic [PA_W-1:0]    pa_rise_i,
  input  logic [PA_W-1:0]    pa_en_i,
  input  logic [4*NIB_N-1:0] px_i,
  input  logic [NIB_N-1:0]   px_rise_i,
  input  logic [NIB_N-1:0]   px_en_i,
  output logic               hit_o
);
  localparam int PX_W = 4 * NIB_N;

  logic [PA_W-1:0]  pa_q, pa_d;
  logic [PX_W-1:0]  px_q, px_d;
  logic [PA_W-1:0]  pa_hit;
  logic [NIB_N-1:0] nib_hit;
  logic             smp_en;

  // history registers track the pins every cycle
  assign smp_en = 1'b1;

  always_comb begin
    pa_d = pa_q;
    px_d = px_q;
    if (smp_en) begin
      pa_d = pa_i;
      px_d = px_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      px_q <= '0;
    end else begin
      pa_q <= pa_d;
      px_q <= px_d;
    end
  end

  for (genvar p = 0; p < PA_W; p++) begin : g_pa
    logic up, dn;
    assign up        = pa_i[p] & ~pa_q[p];
    assign dn        = ~pa_i[p] & pa_q[p];
    assign pa_hit[p] = pa_en_i[p] & (pa_rise_i[p] ? up : dn);
  end

  for (genvar n = 0; n < NIB_N; n++) begin : g_nib
    logic [3:0] cur, prv;
    assign cur        = px_i[4*n +: 4];
    assign prv        = px_q[4*n +: 4];
    assign nib_hit[n] = px_en_i[n] &
                        (px_rise_i[n] ? |(cur & ~prv) : |(~cur & prv));
  end

  assign hit_o = (|pa_hit) | (|nib_hit);
endmodule

// File: rtl/pdw_irq_arb.sv
module pdw_irq_arb #(
  parameter int IRQ_N = 4,
  localparam int IW   = (IRQ_N > 1) ? $clog2(IRQ_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_i,
  input  logic [IRQ_N-1:0] req_i,
  input  logic [IRQ_N-1:0] en_i,
  input  logic             stack_full_i,
  output logic             hit_o,
  output logic [IW-1:0]    sel_o,
  output logic             serve_o
);
  logic [IRQ_N-1:0] arm_q, arm_d;
  logic [IRQ_N-1:0] live;

  // requests already up at halt time are disarmed for that halt
  always_comb begin
    arm_d = arm_q;
    if (snap_i) arm_d = ~req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_d;
  end

  assign live  = req_i & arm_q;
  assign hit_o = |live;

  always_comb begin
    sel_o = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (live[i]) sel_o = IW'(i);
    end
  end

  assign serve_o = en_i[sel_o] & ~stack_full_i;
endmodule

// File: rtl/pdw_settle_tmr.sv
module pdw_settle_tmr #(
  parameter int SETTLE_CYC = 512,
  localparam int CW        = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)    cnt_d = '0;
    else if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == CW'(SETTLE_CYC - 1));
endmodule

// File: rtl/pdwake_ctrl.sv
module pdwake_ctrl
  import pdw_pkg::*;
#(
  parameter int PA_W       = 8,
  parameter int NIB_N      = 4,
  parameter int IRQ_N      = 4,
  parameter int SETTLE_CYC = 512,
  localparam int PX_W      = 4 * NIB_N,
  localparam int IW        = (IRQ_N > 1) ? $clog2(IRQ_N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_i,
  input  logic               wdt_clr_i,
  input  logic               ext_rst_i,
  input  logic               wdt_ovf_i,
  input  logic               ptr_ovf_i,
  input  logic               ptr_zero_i,
  input  logic [PA_W-1:0]    pa_i,
  input  logic [PA_W-1:0]    pa_rise_i,
  input  logic [PA_W-1:0]    pa_en_i,
  input  logic [PX_W-1:0]    px_i,
  input  logic [NIB_N-1:0]   px_rise_i,
  input  logic [NIB_N-1:0]   px_en_i,
  input  logic [IRQ_N-1:0]   irq_req_i,
  input  logic [IRQ_N-1:0]   irq_en_i,
  input  logic               stack_full_i,
  output logic               halted_o,
  output logic [ACT_W-1:0]   act_o,
  output logic [IW-1:0]      irq_sel_o,
  output logic               pd_flag_o,
  output logic               to_flag_o
);
  logic             rst_sn;
  pdw_state_e       st_q, st_d;
  logic [ACT_W-1:0] act_q, act_d, pend_q, pend_d;
  logic [IW-1:0]    sel_q, sel_d;
  logic             pd_q, pd_d, to_q, to_d;
  logic             settling, asleep, halt_take;
  logic             pin_hit, irq_hit, irq_serve, tmr_done, tmr_start;
  logic [IW-1:0]    irq_pick;
  logic             wake_wdt, wake_ptr, wake_any;

  pdw_rst_sync u_rsync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sn)
  );

  assign settling  = (st_q == ST_SETTLE);
  assign asleep    = (st_q == ST_SLEEP);
  assign halt_take = (st_q == ST_RUN) && halt_i;

  pdw_edge_det #(.PA_W(PA_W), .NIB_N(NIB_N)) u_edge (
    .clk       (clk),
    .rst_n     (rst_sn),
    .pa_i      (pa_i),
    .pa_rise_i (pa_rise_i),
    .pa_en_i   (pa_en_i),
    .px_i      (px_i),
    .px_rise_i (px_rise_i),
    .px_en_i   (px_en_i),
    .hit_o     (pin_hit)
  );

  pdw_irq_arb #(.IRQ_N(IRQ_N)) u_irq (
    .clk          (clk),
    .rst_n        (rst_sn),
    .snap_i       (halt_take),
    .req_i        (irq_req_i),
    .en_i         (irq_en_i),
    .stack_full_i (stack_full_i),
    .hit_o        (irq_hit),
    .sel_o        (irq_pick),
    .serve_o      (irq_serve)
  );

  pdw_settle_tmr #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start_i (tmr_start),
    .run_i   (settling),
    .done_o  (tmr_done)
  );

  // the period-timer register contents pick which overflow may wake
  assign wake_wdt = wdt_ovf_i & ptr_zero_i;
  assign wake_ptr = ptr_ovf_i & ~ptr_zero_i;
  assign wake_any = ext_rst_i | wake_wdt | wake_ptr | irq_hit | pin_hit;

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    sel_d     = sel_q;
    pd_d      = pd_q;
    to_d      = to_q;
    act_d     = ACT_NONE;
    tmr_start = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (halt_i) begin
          st_d = ST_SLEEP;
          pd_d = 1'b1;
        end else if (wdt_clr_i) begin
          pd_d = 1'b0;
        end
      end
      ST_SLEEP: begin
        if (wake_any) begin
          st_d      = ST_SETTLE;
          tmr_start = 1'b1;
          if (ext_rst_i) begin
            pend_d = ACT_FULL;
          end else if (wake_wdt) begin
            pend_d = ACT_PCSP;
            to_d   = 1'b1;
          end else if (wake_ptr) begin
            pend_d = ACT_NEXT;
          end else if (irq_hit) begin
            pend_d = irq_serve ? ACT_IRQ : ACT_NEXT;
            sel_d  = irq_pick;
          end else begin
            pend_d = ACT_NEXT;
          end
        end
      end
      ST_SETTLE: begin
        if (ext_rst_i) pend_d = ACT_FULL;
        if (tmr_done) begin
          st_d  = ST_RUN;
          act_d = pend_d;
          if (pend_d == ACT_FULL) begin
            pd_d = 1'b0;
            to_d = 1'b0;
          end
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_RUN;
      act_q  <= ACT_NONE;
      pend_q <= ACT_NONE;
      sel_q  <= '0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pd_q <= 1'b0;
      to_q <= 1'b0;
    end else begin
      pd_q <= pd_d;
      to_q <= to_d;
    end
  end

  assign halted_o  = asleep | settling;
  assign act_o     = act_q;
  assign irq_sel_o = sel_q;
  assign pd_flag_o = pd_q;
  assign to_flag_o = to_q;
endmodule

// File: rtl/pdw_chk.sv
module pdw_chk #(
  parameter int SETTLE_CYC = 512,
  localparam int CNT_W     = $clog2(SETTLE_CYC + 1) + 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_i,
  input logic       wdt_ovf_i,
  input logic       ptr_zero_i,
  input logic       settling,
  input logic       halted_o,
  input logic [3:0] act_o,
  input logic       pd_flag_o,
  input logic       to_flag_o
);
  logic [CNT_W-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_q <= '0;
    else if (settling) win_q <= (win_q == {CNT_W{1'b1}}) ? win_q : win_q + 1'b1;
    else               win_q <= '0;
  end

  // R2
  act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_o));

  // R2
  act_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o != 4'b0) |=> (act_o == 4'b0));

  // R2
  act_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o != 4'b0) |-> (win_q == CNT_W'(SETTLE_CYC)));

  // R2
  act_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o != 4'b0) |-> (!halted_o && $past(halted_o)));

  // R1
  pd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_flag_o) |-> $past(halt_i));

  // R4
  to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag_o) |-> $past(wdt_ovf_i && ptr_zero_i));

  // R3
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_o[0] |-> (!pd_flag_o && !to_flag_o));
endmodule

bind pdwake_ctrl pdw_chk #(.SETTLE_CYC(SETTLE_CYC)) u_pdw_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt_i     (halt_i),
  .wdt_ovf_i  (wdt_ovf_i),
  .ptr_zero_i (ptr_zero_i),
  .settling   (settling),
  .halted_o   (halted_o),
  .act_o      (act_o),
  .pd_flag_o  (pd_flag_o),
  .to_flag_o  (to_flag_o)
);

// File: tb/tb_pdwake_ctrl.sv
`timescale 1ns/1ps
module tb_pdwake_ctrl;
  localparam int PA_W = 8, NIB_N = 4, IRQ_N = 4, SC = 512;
  localparam int VW = 22, NV = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic halt_i, wdt_clr_i, ext_rst_i, wdt_ovf_i, ptr_ovf_i, ptr_zero_i;
  logic [PA_W-1:0] pa_i, pa_rise_i, pa_en_i;
  logic [4*NIB_N-1:0] px_i;
  logic [NIB_N-1:0] px_rise_i, px_en_i;
  logic [IRQ_N-1:0] irq_req_i, irq_en_i;
  logic stack_full_i, halted_o, pd_flag_o, to_flag_o;
  logic [3:0] act_o;
  logic [1:0] irq_sel_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  pdwake_ctrl dut (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .wdt_clr_i(wdt_clr_i),
    .ext_rst_i(ext_rst_i), .wdt_ovf_i(wdt_ovf_i), .ptr_ovf_i(ptr_ovf_i),
    .ptr_zero_i(ptr_zero_i), .pa_i(pa_i), .pa_rise_i(pa_rise_i),
    .pa_en_i(pa_en_i), .px_i(px_i), .px_rise_i(px_rise_i), .px_en_i(px_en_i),
    .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .stack_full_i(stack_full_i),
    .halted_o(halted_o), .act_o(act_o), .irq_sel_o(irq_sel_o),
    .pd_flag_o(pd_flag_o), .to_flag_o(to_flag_o)
  );

  typedef struct packed {
    logic       ext, wdt, ptro, ptrz;
    logic [3:0] irq, ien;
    logic       sfull, pin_a, pin_x;
    logic [3:0] act;
    logic       to;
    logic [1:0] sel;
  } vec_t;

  // act codes: 0001 full, 0010 pc/sp, 0100 next, 1000 irq
  localparam logic [VW-1:0] VECS [NV] = '{
    {4'b1001, 4'b0000, 4'b0000, 3'b000, 4'b0001, 1'b0, 2'd0}, // R3 ext
    {4'b0101, 4'b0000, 4'b0000, 3'b000, 4'b0010, 1'b1, 2'd0}, // R4 wdt
    {4'b0010, 4'b0000, 4'b0000, 3'b000, 4'b0100, 1'b0, 2'd0}, // R5 period timer
    {4'b0001, 4'b0001, 4'b0001, 3'b000, 4'b1000, 1'b0, 2'd0}, // R7 serve
    {4'b0001, 4'b0010, 4'b0000, 3'b000, 4'b0100, 1'b0, 2'd0}, // R7 disabled
    {4'b0001, 4'b0100, 4'b0100, 3'b100, 4'b0100, 1'b0, 2'd0}, // R7 stack full
    {4'b0001, 4'b0000, 4'b0000, 3'b010, 4'b0100, 1'b0, 2'd0}, // R6 port A rise
    {4'b0001, 4'b0000, 4'b0000, 3'b001, 4'b0100, 1'b0, 2'd0}, // R6 nibble fall
    {4'b1101, 4'b0001, 4'b0001, 3'b000, 4'b0001, 1'b0, 2'd0}, // R9 ext wins
    {4'b0101, 4'b0001, 4'b0001, 3'b000, 4'b0010, 1'b1, 2'd0}, // R9 wdt over irq
    {4'b0001, 4'b1010, 4'b1010, 3'b000, 4'b1000, 1'b0, 2'd1}, // R7 lowest index
    {4'b0100, 4'b0001, 4'b0001, 3'b000, 4'b1000, 1'b0, 2'd0}  // R5 masked wdt
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    halt_i = 0; wdt_clr_i = 0; ext_rst_i = 0; wdt_ovf_i = 0; ptr_ovf_i = 0;
    ptr_zero_i = 1; irq_req_i = '0; irq_en_i = '0; stack_full_i = 0;
    pa_i = 8'h20; px_i = 16'h00F0;
    pa_rise_i = 8'h04; pa_en_i = 8'h24; px_rise_i = 4'b0000; px_en_i = 4'b0010;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_halt(input string tag);
    halt_i = 1;
    @(negedge clk);
    halt_i = 0;
    chk(halted_o === 1'b1, tag, 32'(halted_o), 1);
    chk(pd_flag_o === 1'b1, tag, 32'(pd_flag_o), 1);
  endtask

  // call at the negedge where the wake strobes were placed
  task automatic finish_wake(input string tag, input logic [3:0] ea,
                             input logic eto, input logic epd, input logic [1:0] es);
    @(negedge clk);
    ext_rst_i = 0; wdt_ovf_i = 0; ptr_ovf_i = 0; irq_req_i = '0;
    repeat (SC - 1) @(negedge clk);
    chk(act_o === 4'b0 && halted_o === 1'b1, {tag, " early"}, {act_o, 3'b0, halted_o}, 32'h1);
    @(negedge clk);
    chk(act_o === ea, {tag, " action"}, 32'(act_o), 32'(ea));
    chk(halted_o === 1'b0, {tag, " release"}, 32'(halted_o), 0);
    chk(to_flag_o === eto, {tag, " to"}, 32'(to_flag_o), 32'(eto));
    chk(pd_flag_o === epd, {tag, " pd"}, 32'(pd_flag_o), 32'(epd));
    if (ea == 4'b1000) chk(irq_sel_o === es, {tag, " sel"}, 32'(irq_sel_o), 32'(es));
    @(negedge clk);
    chk(act_o === 4'b0, {tag, " pulse"}, 32'(act_o), 0);
  endtask

  task automatic wait_quiet(input int n, input string tag);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (act_o != 4'b0 || halted_o !== 1'b1) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    // R10 reset state
    chk(act_o === 4'b0, "R10 reset act", 32'(act_o), 0);
    chk(halted_o === 1'b0, "R10 reset halted", 32'(halted_o), 0);
    chk(pd_flag_o === 1'b0 && to_flag_o === 1'b0, "R10 reset flags",
        {pd_flag_o, to_flag_o}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      do_reset();
      ptr_zero_i = v.ptrz; irq_en_i = v.ien; stack_full_i = v.sfull;
      @(negedge clk);
      do_halt($sformatf("R1 vec%0d halt", i));
      ext_rst_i = v.ext; wdt_ovf_i = v.wdt; ptr_ovf_i = v.ptro; irq_req_i = v.irq;
      if (v.pin_a) pa_i[2] = 1'b1;
      if (v.pin_x) px_i[4] = 1'b0;
      finish_wake($sformatf("R2 vec%0d", i), v.act, v.to, (v.act != 4'b0001), v.sel);
    end

    // R5 R6: masked timers, disabled pins, wrong-direction edges are ignored
    do_reset();
    pa_i = 8'h04;
    @(negedge clk);
    do_halt("R1 ignore halt");
    ptr_zero_i = 0; wdt_ovf_i = 1;
    @(negedge clk);
    wdt_ovf_i = 0; ptr_zero_i = 1; ptr_ovf_i = 1;
    @(negedge clk);
    ptr_ovf_i = 0; pa_i = 8'h21; px_i = 16'h00FF;
    @(negedge clk);
    px_i = 16'h01FF;
    @(negedge clk);
    halt_i = 1;
    @(negedge clk);
    halt_i = 0;
    wait_quiet(600, "R5 R6 ignored sources");
    chk(to_flag_o === 1'b0, "R5 to untouched", 32'(to_flag_o), 0);
    ext_rst_i = 1;
    finish_wake("R3 after ignore", 4'b0001, 1'b0, 1'b0, 2'd0);

    // R8: request up before the halt is not a wake source
    do_reset();
    irq_req_i = 4'b0001; irq_en_i = 4'b0011;
    @(negedge clk);
    do_halt("R8 halt");
    wait_quiet(600, "R8 stale irq");
    irq_req_i = 4'b0011;
    finish_wake("R8 fresh irq", 4'b1000, 1'b0, 1'b1, 2'd1);

    // R4 R10: time-out persists over a later wake, clear cmd drops pd only
    do_reset();
    do_halt("R4 halt a");
    wdt_ovf_i = 1;
    finish_wake("R4 wdt", 4'b0010, 1'b1, 1'b1, 2'd0);
    do_halt("R4 halt b");
    pa_i[2] = 1'b1;
    finish_wake("R4 keep to", 4'b0100, 1'b1, 1'b1, 2'd0);
    wdt_clr_i = 1;
    @(negedge clk);
    wdt_clr_i = 0;
    chk(pd_flag_o === 1'b0, "R10 clr pd", 32'(pd_flag_o), 0);
    chk(to_flag_o === 1'b1, "R10 clr keeps to", 32'(to_flag_o), 1);

    // R11: external reset during settling upgrades, window not restarted
    do_reset();
    do_halt("R11 halt");
    pa_i[2] = 1'b1;
    @(negedge clk);
    repeat (100) @(negedge clk);
    ext_rst_i = 1;
    @(negedge clk);
    ext_rst_i = 0;
    repeat (SC - 102) @(negedge clk);
    chk(act_o === 4'b0, "R11 early", 32'(act_o), 0);
    @(negedge clk);
    chk(act_o === 4'b0001, "R11 upgraded", 32'(act_o), 1);
    chk(pd_flag_o === 1'b0, "R11 pd", 32'(pd_flag_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule